// File: doc/BRIEF.md
# Message Automatic Retry Controller

This block sits beside a bus message engine and decides, once a message has finished, whether the message goes out again and on which bus. At the start of each command block the sequencer passes in the block's retry-enable bit and the bus of the first attempt. Each time the engine reports an outcome, the controller compares the outcome flags with a trigger mask. The mask has one bit for each failure kind: remote terminal busy, remote terminal message error, response timeout, and error detected by the controller. The controller then answers with exactly one of two results. It either requests a retry and names the bus for it, or it ends the block with a done pulse and a failed flag.

Configuration sets the retry budget. A small field encodes the budget, with value n meaning n+1 retries. A mode bit chooses whether each retry stays on the bus of the previous attempt or moves to the other bus. Each new command block restarts the attempt count and the bus.

Top module: `retry_ctrl`

## Requirements
- R1: During and after reset, retry_req, done and failed are 0 and retry_bus is 0, and no outcome is accepted until a block has been started.
- R2: If the block was started with blk_retry_en = 0, every accepted outcome ends the block with done and no retry. failed is 1 exactly when a masked trigger is active.
- R3: Trigger flags are out_flags bit 0 = RT busy, bit 1 = RT message error, bit 2 = response timeout, bit 3 = controller-detected error. A flag counts only when the same bit of cfg_trig_mask is 1.
- R4: An accepted outcome with no masked trigger active ends the block with done = 1 and failed = 0, and does not request a retry.
- R5: With cfg_retry_max = n, a block issues at most n+1 retries. When a masked trigger is active at an outcome after n+1 retries, the block ends with done = 1 and failed = 1. failed is never 1 without done.
- R6: With cfg_alt_bus = 0, retry_bus on a retry equals the bus of the previous attempt.
- R7: With cfg_alt_bus = 1, retry_bus on a retry is the inverse of the bus of the previous attempt.
- R8: blk_start, including one that arrives while a block is still open, clears the retry count, loads retry_bus from blk_bus one cycle later, and latches blk_retry_en.
- R9: out_valid is ignored when no block is open, and when it arrives in the same cycle as blk_start.
- R10: retry_req and done are one-cycle pulses that appear in the cycle after the accepted outcome, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Pulse: a new command block begins |
| blk_retry_en | input | 1 | Retry enable of the new block, sampled with blk_start |
| blk_bus | input | 1 | Bus of the first attempt, sampled with blk_start |
| cfg_trig_mask | input | 4 | Per-flag retry trigger enables |
| cfg_alt_bus | input | 1 | 1: each retry moves to the other bus |
| cfg_retry_max | input | CNT_W | Retry budget minus one |
| out_valid | input | 1 | Pulse: the message engine reports an outcome |
| out_flags | input | 4 | Outcome flags, encoded as given in R3 |
| retry_req | output | 1 | Pulse: send the message again |
| retry_bus | output | 1 | Bus for the current attempt |
| done | output | 1 | Pulse: the block is finished |
| failed | output | 1 | With done: the block ended on an enabled failure |

## Verification
The hardest state to reach is the final outcome of a block with the largest budget. To get there the controller must see four triggered outcomes in a row without a new blk_start, and a fifth one to exhaust the budget. With alternate-bus mode on, retry_bus must toggle at each of those steps. The stimulus sweeps every value of cfg_retry_max and feeds a string of failing outcomes until done appears. It then repeats the run with a blk_start injected part way through, and with a blk_start that coincides with an outcome. A behavioural model in the bench tracks the count and the bus, and every output is compared against it on every clock.

// File: rtl/retry_ctrl_pkg.sv
package retry_ctrl_pkg;

    localparam int TRIG_N = 4;

    localparam int TRIG_BUSY    = 0;
    localparam int TRIG_RT_ERR  = 1;
    localparam int TRIG_TIMEOUT = 2;
    localparam int TRIG_CTL_ERR = 3;

    typedef logic [TRIG_N-1:0] trig_vec_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_OPEN = 1'b1
    } phase_e;

    typedef struct packed {
        logic accept;
        logic hit;
        logic retry;
        logic finish;
    } decision_t;

    function automatic logic pick_bus(input logic prev, input logic alt);
        return alt ? ~prev : prev;
    endfunction

endpackage

// File: rtl/retry_trigger_eval.sv
module retry_trigger_eval
    import retry_ctrl_pkg::*;
(
    input  trig_vec_t flags,
    input  trig_vec_t mask,
    output logic      any_hit
);
    trig_vec_t per_bit;

    genvar g;
    generate
        for (g = 0; g < TRIG_N; g++) begin : g_bit
            assign per_bit[g] = flags[g] & mask[g];
        end
    endgenerate

    assign any_hit = |per_bit;
endmodule

// File: rtl/retry_attempt_ctr.sv
module retry_attempt_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit_field,
    output logic             budget_left
);
    localparam int AW = CNT_W + 1;

    logic [AW-1:0] used_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            used_q <= '0;
        end else if (step) begin
            used_q <= used_q + AW'(1);
        end
    end

    // retries used so far must stay below limit_field + 1
    assign budget_left = (used_q <= {1'b0, limit_field});
endmodule

// File: rtl/retry_bus_track.sv
module retry_bus_track
    import retry_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic load_bus,
    input  logic step,
    input  logic alt,
    output logic bus
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus <= 1'b0;
        end else if (load) begin
            bus <= load_bus;
        end else if (step) begin
            bus <= pick_bus(bus, alt);
        end
    end
endmodule

// File: rtl/retry_ctrl.sv
module retry_ctrl
    import retry_ctrl_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_start,
    input  logic             blk_retry_en,
    input  logic             blk_bus,
    input  logic [3:0]       cfg_trig_mask,
    input  logic             cfg_alt_bus,
    input  logic [CNT_W-1:0] cfg_retry_max,
    input  logic             out_valid,
    input  logic [3:0]       out_flags,
    output logic             retry_req,
    output logic             retry_bus,
    output logic             done,
    output logic             failed
);
    phase_e    phase_q;
    logic      en_q;
    logic      trig_any;
    logic      budget_left;
    decision_t dec;

    retry_trigger_eval i_eval (
        .flags   (out_flags),
        .mask    (cfg_trig_mask),
        .any_hit (trig_any)
    );

    retry_attempt_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk         (clk),
        .rst         (rst),
        .clear       (blk_start),
        .step        (dec.retry),
        .limit_field (cfg_retry_max),
        .budget_left (budget_left)
    );

    retry_bus_track i_bus (
        .clk      (clk),
        .rst      (rst),
        .load     (blk_start),
        .load_bus (blk_bus),
        .step     (dec.retry),
        .alt      (cfg_alt_bus),
        .bus      (retry_bus)
    );

    always_comb begin
        dec.accept = (phase_q == PH_OPEN) && out_valid && !blk_start;
        dec.hit    = trig_any && en_q;
        dec.retry  = dec.accept && dec.hit && budget_left;
        dec.finish = dec.accept && !dec.retry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            en_q      <= 1'b0;
            retry_req <= 1'b0;
            done      <= 1'b0;
            failed    <= 1'b0;
        end else begin
            retry_req <= dec.retry;
            done      <= dec.finish;
            failed    <= dec.finish && trig_any;
            if (blk_start) begin
                phase_q <= PH_OPEN;
                en_q    <= blk_retry_en;
            end else if (dec.finish) begin
                phase_q <= PH_IDLE;
            end
        end
    end
endmodule

// File: rtl/retry_ctrl_chk.sv
module retry_ctrl_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             blk_start,
    input logic             blk_retry_en,
    input logic             blk_bus,
    input logic             cfg_alt_bus,
    input logic [CNT_W-1:0] cfg_retry_max,
    input logic             out_valid,
    input logic             retry_req,
    input logic             retry_bus,
    input logic             done,
    input logic             failed
);
    logic [CNT_W:0] seen_q;
    logic           en_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q    <= '0;
            en_seen_q <= 1'b0;
        end else if (blk_start) begin
            seen_q    <= '0;
            en_seen_q <= blk_retry_en;
        end else if (retry_req) begin
            seen_q    <= seen_q + 1'b1;
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(retry_req && done)); // R10
    AST_OUT_NEEDS_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        (retry_req || done) |-> ($past(out_valid) && !$past(blk_start))); // R9
    AST_FAIL_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
        failed |-> done); // R5
    AST_RETRY_BUDGET: assert property (@(posedge clk) disable iff (rst)
        retry_req |-> (seen_q <= {1'b0, $past(cfg_retry_max)})); // R5
    AST_RETRY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        retry_req |-> en_seen_q); // R2
    AST_BUS_SAME: assert property (@(posedge clk) disable iff (rst)
        (retry_req && !$past(cfg_alt_bus)) |-> (retry_bus == $past(retry_bus))); // R6
    AST_BUS_FLIP: assert property (@(posedge clk) disable iff (rst)
        (retry_req && $past(cfg_alt_bus)) |-> (retry_bus != $past(retry_bus))); // R7
    AST_BUS_LOAD: assert property (@(posedge clk) disable iff (rst)
        ($past(blk_start) && !$past(rst)) |-> (retry_bus == $past(blk_bus))); // R8
endmodule

bind retry_ctrl retry_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .blk_start     (blk_start),
    .blk_retry_en  (blk_retry_en),
    .blk_bus       (blk_bus),
    .cfg_alt_bus   (cfg_alt_bus),
    .cfg_retry_max (cfg_retry_max),
    .out_valid     (out_valid),
    .retry_req     (retry_req),
    .retry_bus     (retry_bus),
    .done          (done),
    .failed        (failed)
);

// File: tb/test_retry_ctrl.sv
`timescale 1ns/100ps
module test_retry_ctrl;
    localparam int CNT_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             blk_start = 1'b0;
    logic             blk_retry_en = 1'b0;
    logic             blk_bus = 1'b0;
    logic [3:0]       cfg_trig_mask = 4'hF;
    logic             cfg_alt_bus = 1'b0;
    logic [CNT_W-1:0] cfg_retry_max = '0;
    logic             out_valid = 1'b0;
    logic [3:0]       out_flags = 4'h0;
    logic             retry_req, retry_bus, done, failed;

    int    total = 0;
    int    bad = 0;
    string tag = "R1";

    // reference model state
    bit m_open = 0, m_en = 0, m_bus = 0;
    int m_used = 0;
    bit e_req = 0, e_done = 0, e_fail = 0;

    always #2.5 clk = ~clk;

    retry_ctrl #(.CNT_W(CNT_W)) i_retry_ctrl (
        .clk(clk), .rst(rst), .blk_start(blk_start), .blk_retry_en(blk_retry_en),
        .blk_bus(blk_bus), .cfg_trig_mask(cfg_trig_mask), .cfg_alt_bus(cfg_alt_bus),
        .cfg_retry_max(cfg_retry_max), .out_valid(out_valid), .out_flags(out_flags),
        .retry_req(retry_req), .retry_bus(retry_bus), .done(done), .failed(failed)
    );

    always @(posedge clk) begin
        e_req = 0; e_done = 0; e_fail = 0;
        if (rst) begin
            m_open = 0; m_en = 0; m_bus = 0; m_used = 0;
        end else if (blk_start) begin
            m_open = 1; m_en = blk_retry_en; m_bus = blk_bus; m_used = 0;
        end else if (m_open && out_valid) begin
            if (m_en && ((out_flags & cfg_trig_mask) != 0) && (m_used < int'(cfg_retry_max) + 1)) begin
                e_req = 1;
                m_used++;
                if (cfg_alt_bus) m_bus = ~m_bus;
            end else begin
                e_done = 1;
                e_fail = ((out_flags & cfg_trig_mask) != 0);
                m_open = 0;
            end
        end
    end

    task automatic check(input string t, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check(tag, "retry_req", int'(retry_req), int'(e_req));
        check(tag, "done", int'(done), int'(e_done));
        check(tag, "failed", int'(failed), int'(e_fail));
        check(tag, "retry_bus", int'(retry_bus), int'(m_bus));
        if (retry_req && done) check("R10", "exclusive pulses", 1, 0);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_blk(input bit en, input bit bus);
        @(negedge clk);
        blk_start = 1; blk_retry_en = en; blk_bus = bus;
        @(negedge clk);
        blk_start = 0;
    endtask

    task automatic outcome(input logic [3:0] f);
        @(negedge clk);
        out_valid = 1; out_flags = f;
        @(negedge clk);
        out_valid = 0; out_flags = 4'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tag = "R1";
        idle(3);
        rst = 0;
        idle(2);
        check("R1", "idle done", int'(done), 0);
        outcome(4'h1);                       // R9: nothing open yet
        idle(2);

        tag = "R4";
        start_blk(1, 0);
        outcome(4'h0);
        idle(2);

        tag = "R3";
        cfg_trig_mask = 4'b0001;
        start_blk(1, 0);
        outcome(4'b0010);                    // unmasked message error: done, no fail
        start_blk(1, 0);
        outcome(4'b0001);                    // masked busy: retry
        outcome(4'b0000);
        for (int b = 0; b < 4; b++) begin
            cfg_trig_mask = 4'(1 << b);
            start_blk(1, 1);
            outcome(4'(1 << b));
            outcome(4'(1 << ((b + 1) % 4)));
        end
        cfg_trig_mask = 4'hF;

        tag = "R2";
        start_blk(0, 1);
        outcome(4'b0100);
        start_blk(0, 0);
        outcome(4'b0000);

        tag = "R5";
        for (int n = 0; n < 4; n++) begin
            cfg_retry_max = n[CNT_W-1:0];
            cfg_alt_bus = 1'(n % 2);
            start_blk(1, 1);
            for (int k = 0; k < n + 2; k++) outcome(4'b1000);
            idle(1);
        end

        tag = "R6";
        cfg_retry_max = 2'd3; cfg_alt_bus = 0;
        start_blk(1, 1);
        repeat (3) outcome(4'b0001);
        outcome(4'b0000);

        tag = "R7";
        cfg_alt_bus = 1;
        start_blk(1, 0);
        repeat (5) outcome(4'b0100);

        tag = "R8";
        cfg_retry_max = 2'd1;
        start_blk(1, 0);
        outcome(4'b0010);
        outcome(4'b0010);
        start_blk(1, 1);                     // restart while open
        outcome(4'b0010);
        outcome(4'b0010);
        outcome(4'b0010);

        tag = "R9";
        start_blk(1, 0);
        @(negedge clk);
        blk_start = 1; blk_retry_en = 1; blk_bus = 1; out_valid = 1; out_flags = 4'hF;
        @(negedge clk);
        blk_start = 0; out_valid = 0; out_flags = 0;
        outcome(4'h0);
        outcome(4'hF);                       // block already closed
        idle(2);

        tag = "R10";
        cfg_alt_bus = 0; cfg_retry_max = 0;
        start_blk(1, 1);
        @(negedge clk);
        out_valid = 1; out_flags = 4'h1;
        @(negedge clk);
        out_flags = 4'h1;                    // back-to-back outcomes
        @(negedge clk);
        out_valid = 0; out_flags = 0;
        idle(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule